// File: doc/BRIEF.md
# UART interrupt identifier

This block turns the interrupt causes of a serial port controller into a single interrupt request and an 8-bit identification value that the host reads to find the cause. It holds the 4-bit interrupt enable register. It also owns two pieces of state. The first is the transmitter-empty pending flag, which register accesses set and clear. The second is the pair of sticky overrun and break flags, which a read of the line status register clears.

The receive FIFO occupancy, trigger level, data-ready, timeout-pending, parity and framing error levels and modem delta bits come in from neighbouring logic. Host accesses reach the block as single-cycle read and write strobes with a 3-bit register address. A divisor-select input redirects addresses 0 and 1 away from the data and enable registers. The identification value and the request output are registered.

Top module: `uart_int_ident`

## Requirements
- R1: Line status has the highest priority. When enable bit 2 is set and any of overrun, break, parity error or framing error is active, the identification value has bits 3:0 = 0x6.
- R2: Character timeout comes second. When enable bit 0 is set and timeout is pending, bits 3:0 = 0xC.
- R3: Receive data comes third, with bits 3:0 = 0x4. It requires enable bit 0, data ready, and either FIFOs off or occupancy greater than or equal to the trigger level.
- R4: Transmitter empty comes fourth, with bits 3:0 = 0x2, when enable bit 1 and the pending flag are set. Modem status is lowest, with bits 3:0 = 0x0, when enable bit 3 is set and any delta bit is set.
- R5: With no active cause, bits 3:0 = 0x1. The request output is high exactly when bits 3:0 differ from 0x1.
- R6: Bits 7:6 of the identification value are 11 while FIFOs are on and 00 while they are off. Bits 5:4 are always 0.
- R7: The identification value and the request output change one clock edge after their cause changes.
- R8: A read of address 2 while bits 3:0 show 0x2 clears the pending flag. A read of address 2 showing any other code leaves the flag unchanged.
- R9: A write to address 0 with divisor select low clears the pending flag. A one-cycle tx_drained pulse sets it.
- R10: A write to address 1 that changes enable bit 1 sets the pending flag to the new bit 1 ANDed with thr_empty.
- R11: A read of address 5 clears the overrun and break flags. The parity and framing levels are left as they are. An overrun or break event in the same cycle as the read wins over the clear.
- R12: A write to address 1 stores only data bits 3:0. Writes to addresses 0 and 1 with divisor select high leave the enable register and the pending flag untouched.
- R13: After reset the enable register is 0, both sticky flags and the pending flag are 0, the identification value is 0x01 and the request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| div_sel | input | 1 | Addresses 0 and 1 select the divisor latch |
| fifo_on | input | 1 | FIFOs enabled |
| rx_ready | input | 1 | Receive data ready |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| rx_trigger | input | CNT_W | Receive trigger level in bytes |
| rx_timeout | input | 1 | Character timeout pending |
| par_err | input | 1 | Parity error level |
| frm_err | input | 1 | Framing error level |
| ovr_evt | input | 1 | Overrun event pulse |
| brk_evt | input | 1 | Break event pulse |
| thr_empty | input | 1 | Holding register or transmit FIFO empty |
| tx_drained | input | 1 | Pulse: last byte has moved to the shift register |
| modem_delta | input | 4 | Modem status delta bits |
| enable_q | output | 4 | Interrupt enable register |
| ovr_flag | output | 1 | Sticky overrun flag |
| brk_flag | output | 1 | Sticky break flag |
| int_id | output | 8 | Registered identification value |
| int_req | output | 1 | Registered interrupt request |

## Verification
The bench targets priority collisions in which several causes are active at once. An encoder with the wrong ranking would report timeout or modem status while a line error is pending. It probes the trigger comparison at exactly the trigger level, where an off-by-one would leave the receive cause silent, and it checks the FIFOs-off case, where occupancy must not matter. The transmitter-empty flag is exercised through read-clear, read-with-another-code, enable re-arm with the holding register both full and empty, and divisor-select writes; a design that clears the flag on any identification read would lose the transmit interrupt behind a timeout. For the sticky flags it checks collision of a clear with a new event and confirms that a read leaves the parity level alone.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_TXEMPTY = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } id_code_t;

  localparam int EN_RXDATA = 0;
  localparam int EN_TXEMPTY = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_W = 4;

endpackage

// File: rtl/uart_int_enable.sv
module uart_int_enable
  import uart_int_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_enable,
  input  logic            wr_data,
  input  logic            rd_ident,
  input  logic            id_is_tx,
  input  logic [EN_W-1:0] wdata,
  input  logic            thr_empty,
  input  logic            tx_drained,
  output logic [EN_W-1:0] en_q,
  output logic            pend_q
);

  logic [EN_W-1:0] en_d;
  logic            pend_d;
  logic            tx_bit_flip;

  assign tx_bit_flip = wr_enable & (wdata[EN_TXEMPTY] ^ en_q[EN_TXEMPTY]);

  always_comb begin
    en_d = en_q;
    if (wr_enable) en_d = wdata;
  end

  // Arbitration: enable toggle, then data write, then drain, then id read.
  always_comb begin
    pend_d = pend_q;
    if (tx_bit_flip)
      pend_d = wdata[EN_TXEMPTY] & thr_empty;
    else if (wr_data)
      pend_d = 1'b0;
    else if (tx_drained)
      pend_d = 1'b1;
    else if (rd_ident && id_is_tx)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/uart_int_sticky.sv
module uart_int_sticky #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set_evt,
  input  logic           clr,
  output logic [NUM-1:0] flag_q
);

  for (genvar i = 0; i < NUM; i++) begin : g_flag
    logic flag_d;
    logic flag_ce;

    assign flag_ce = set_evt[i] | clr;

    always_comb begin
      flag_d = flag_q[i];
      if (set_evt[i])
        flag_d = 1'b1;
      else if (clr)
        flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (flag_ce)
        flag_q[i] <= flag_d;
    end
  end

endmodule

// File: rtl/uart_int_prio.sv
module uart_int_prio
  import uart_int_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [EN_W-1:0]  en,
  input  logic             line_any,
  input  logic             rx_timeout,
  input  logic             rx_ready,
  input  logic             fifo_on,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             tx_pend,
  input  logic [3:0]       modem_delta,
  output id_code_t         code
);

  logic level_met;
  assign level_met = !fifo_on || (rx_level >= rx_trigger);

  always_comb begin
    code = ID_NONE;
    if (en[EN_LINE] && line_any)
      code = ID_LINE;
    else if (en[EN_RXDATA] && rx_timeout)
      code = ID_TIMEOUT;
    else if (en[EN_RXDATA] && rx_ready && level_met)
      code = ID_RXDATA;
    else if (en[EN_TXEMPTY] && tx_pend)
      code = ID_TXEMPTY;
    else if (en[EN_MODEM] && (|modem_delta))
      code = ID_MODEM;
  end

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_int_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int A_DATA  = 0,
  parameter int A_ENA   = 1,
  parameter int A_IDENT = 2,
  parameter int A_LSTAT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              div_sel,
  input  logic              fifo_on,
  input  logic              rx_ready,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [CNT_W-1:0]  rx_trigger,
  input  logic              rx_timeout,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              ovr_evt,
  input  logic              brk_evt,
  input  logic              thr_empty,
  input  logic              tx_drained,
  input  logic [3:0]        modem_delta,
  output logic [EN_W-1:0]   enable_q,
  output logic              ovr_flag,
  output logic              brk_flag,
  output logic [7:0]        int_id,
  output logic              int_req
);

  localparam int NUM_STICKY = 2;

  logic wr_data, wr_enable, rd_ident, rd_lstat;
  logic pend_q;
  logic [NUM_STICKY-1:0] sticky_q;
  logic line_any;
  logic id_is_tx;
  id_code_t code;
  logic [7:0] id_d;
  logic req_d;

  assign wr_data   = bus_wr & (bus_addr == ADDR_W'(A_DATA)) & ~div_sel;
  assign wr_enable = bus_wr & (bus_addr == ADDR_W'(A_ENA)) & ~div_sel;
  assign rd_ident  = bus_rd & (bus_addr == ADDR_W'(A_IDENT));
  assign rd_lstat  = bus_rd & (bus_addr == ADDR_W'(A_LSTAT));
  assign id_is_tx  = (int_id[3:0] == ID_TXEMPTY);

  uart_int_enable u_enable (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_enable  (wr_enable),
    .wr_data    (wr_data),
    .rd_ident   (rd_ident),
    .id_is_tx   (id_is_tx),
    .wdata      (bus_wdata[EN_W-1:0]),
    .thr_empty  (thr_empty),
    .tx_drained (tx_drained),
    .en_q       (enable_q),
    .pend_q     (pend_q)
  );

  uart_int_sticky #(.NUM(NUM_STICKY)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt ({brk_evt, ovr_evt}),
    .clr     (rd_lstat),
    .flag_q  (sticky_q)
  );

  assign ovr_flag = sticky_q[0];
  assign brk_flag = sticky_q[1];
  assign line_any = ovr_flag | brk_flag | par_err | frm_err;

  uart_int_prio #(.CNT_W(CNT_W)) u_prio (
    .en          (enable_q),
    .line_any    (line_any),
    .rx_timeout  (rx_timeout),
    .rx_ready    (rx_ready),
    .fifo_on     (fifo_on),
    .rx_level    (rx_level),
    .rx_trigger  (rx_trigger),
    .tx_pend     (pend_q),
    .modem_delta (modem_delta),
    .code        (code)
  );

  assign id_d  = {{2{fifo_on}}, 2'b00, code};
  assign req_d = (code != ID_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_id  <= {4'h0, ID_NONE};
      int_req <= 1'b0;
    end else begin
      int_id  <= id_d;
      int_req <= req_d;
    end
  end

endmodule

// File: rtl/uart_int_ident_chk.sv
module uart_int_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       div_sel,
  input logic       fifo_on,
  input logic       par_err,
  input logic       frm_err,
  input logic       ovr_evt,
  input logic       brk_evt,
  input logic [3:0] enable_q,
  input logic       ovr_flag,
  input logic       brk_flag,
  input logic       thr_pend,
  input logic [7:0] int_id,
  input logic       int_req
);

  AST_REQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    int_req == (int_id[3:0] != 4'h1)); // R5

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q[2] && (ovr_flag || brk_flag || par_err || frm_err)) |=> (int_id[3:0] == 4'h6)); // R1

  AST_FIFO_BITS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on |=> (int_id[7:4] == 4'b1100)); // R6

  AST_FIFO_BITS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |=> (int_id[7:4] == 4'b0000)); // R6

  AST_ENABLE_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && !div_sel) |=> (enable_q == $past(bus_wdata[3:0]))); // R12

  AST_DATA_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && !div_sel) |=> !thr_pend); // R9

  AST_LSTAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5 && !ovr_evt && !brk_evt) |=> (!ovr_flag && !brk_flag)); // R11

endmodule

bind uart_int_ident uart_int_ident_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .div_sel   (div_sel),
  .fifo_on   (fifo_on),
  .par_err   (par_err),
  .frm_err   (frm_err),
  .ovr_evt   (ovr_evt),
  .brk_evt   (brk_evt),
  .enable_q  (enable_q),
  .ovr_flag  (ovr_flag),
  .brk_flag  (brk_flag),
  .thr_pend  (pend_q),
  .int_id    (int_id),
  .int_req   (int_req)
);

// File: tb/uart_int_ident_test.sv
module uart_int_ident_test;

  localparam int CNT_W = 5;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd, div_sel, fifo_on, rx_ready, rx_timeout;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [CNT_W-1:0] rx_level, rx_trigger;
  logic par_err, frm_err, ovr_evt, brk_evt, thr_empty, tx_drained;
  logic [3:0] modem_delta;
  logic [3:0] enable_q;
  logic ovr_flag, brk_flag, int_req;
  logic [7:0] int_id;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  uart_int_ident #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .div_sel(div_sel),
    .fifo_on(fifo_on), .rx_ready(rx_ready), .rx_level(rx_level),
    .rx_trigger(rx_trigger), .rx_timeout(rx_timeout), .par_err(par_err),
    .frm_err(frm_err), .ovr_evt(ovr_evt), .brk_evt(brk_evt),
    .thr_empty(thr_empty), .tx_drained(tx_drained), .modem_delta(modem_delta),
    .enable_q(enable_q), .ovr_flag(ovr_flag), .brk_flag(brk_flag),
    .int_id(int_id), .int_req(int_req)
  );

  // {enable[4], par, frm, timeout, ready, fifo, level[5], trigger[5], delta[4], expected id[8]}
  localparam logic [30:0] VEC [NVEC] = '{
    {4'hF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd14, 5'd4, 4'hF, 8'hC6}, // R1
    {4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd14, 5'd4, 4'hF, 8'hCC}, // R2
    {4'hE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd14, 5'd4, 4'hF, 8'hC0}, // R4
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3,  5'd4, 4'h0, 8'hC1}, // R3
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd4,  5'd4, 4'h0, 8'hC4}, // R3
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd4, 4'h0, 8'h04}, // R3
    {4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'd9,  5'd1, 4'hF, 8'h01}, // R5
    {4'h8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0,  5'd1, 4'h2, 8'h00}, // R4
    {4'h4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  5'd1, 4'h0, 8'h06}, // R1
    {4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd10, 5'd1, 4'h0, 8'hC1}  // R6
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_drain();
    tx_drained = 1'b1;
    @(negedge clk);
    tx_drained = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; div_sel = 0;
    fifo_on = 0; rx_ready = 0; rx_level = 0; rx_trigger = 1; rx_timeout = 0;
    par_err = 0; frm_err = 0; ovr_evt = 0; brk_evt = 0; thr_empty = 0;
    tx_drained = 0; modem_delta = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 id", int_id, 8'h01);
    chk("R13 req", {7'd0, int_req}, 8'h00);
    chk("R13 enable", {4'd0, enable_q}, 8'h00);
    chk("R13 flags", {6'd0, brk_flag, ovr_flag}, 8'h00);

    // Priority table
    for (int i = 0; i < NVEC; i++) begin
      logic [30:0] v;
      v = VEC[i];
      par_err = v[26]; frm_err = v[25]; rx_timeout = v[24]; rx_ready = v[23];
      fifo_on = v[22]; rx_level = v[21:17]; rx_trigger = v[16:12];
      modem_delta = v[11:8];
      bus_write(3'd1, {4'h0, v[30:27]});
      settle();
      chk($sformatf("R1-table vec%0d id", i), int_id, v[7:0]);
      chk($sformatf("R5 vec%0d req", i), {7'd0, int_req}, {7'd0, v[3:0] != 4'h1});
    end
    par_err = 0; frm_err = 0; rx_timeout = 0; rx_ready = 0; fifo_on = 0;
    rx_level = 0; modem_delta = 0;

    // R12 upper bits dropped; divisor select blocks the write
    bus_write(3'd1, 8'hF5);
    settle();
    chk("R12 low nibble", {4'd0, enable_q}, 8'h05);
    div_sel = 1'b1;
    bus_write(3'd1, 8'h0A);
    div_sel = 1'b0;
    settle();
    chk("R12 divisor select", {4'd0, enable_q}, 8'h05);

    // R10 enable bit1 rising with holding register empty arms pending
    bus_write(3'd1, 8'h00);
    thr_empty = 1'b1;
    bus_write(3'd1, 8'h02);
    settle();
    chk("R10 armed", int_id, 8'h02);
    chk("R4 tx req", {7'd0, int_req}, 8'h01);
    // R8 read while showing tx code clears
    bus_read(3'd2);
    settle();
    chk("R8 read clears", int_id, 8'h01);
    // R10 toggle re-arms
    bus_write(3'd1, 8'h00);
    bus_write(3'd1, 8'h02);
    settle();
    chk("R10 re-armed", int_id, 8'h02);
    // R12 divisor-select write to address 0 does not clear
    div_sel = 1'b1;
    bus_write(3'd0, 8'h55);
    div_sel = 1'b0;
    settle();
    chk("R12 divisor data write", int_id, 8'h02);
    // R9 data write clears, drain sets
    thr_empty = 1'b0;
    bus_write(3'd0, 8'h41);
    settle();
    chk("R9 write clears", int_id, 8'h01);
    pulse_drain();
    settle();
    chk("R9 drain sets", int_id, 8'h02);
    // R10 enable rise with holding register full leaves pending clear
    bus_write(3'd1, 8'h00);
    bus_write(3'd1, 8'h02);
    settle();
    chk("R10 full no arm", int_id, 8'h01);
    // R8 read showing another code keeps pending
    pulse_drain();
    bus_write(3'd1, 8'h03);
    rx_timeout = 1'b1;
    settle();
    chk("R2 timeout over tx", int_id, 8'h0C);
    bus_read(3'd2);
    rx_timeout = 1'b0;
    settle();
    chk("R8 other code keeps", int_id, 8'h02);
    bus_read(3'd2);
    settle();

    // R11 sticky flags
    bus_write(3'd1, 8'h04);
    ovr_evt = 1'b1;
    @(negedge clk);
    ovr_evt = 1'b0;
    settle();
    chk("R11 overrun set", {6'd0, brk_flag, ovr_flag}, 8'h01);
    chk("R1 overrun id", int_id, 8'h06);
    bus_read(3'd5);
    settle();
    chk("R11 read clears", {6'd0, brk_flag, ovr_flag}, 8'h00);
    chk("R11 id after clear", int_id, 8'h01);
    brk_evt = 1'b1;
    @(negedge clk);
    brk_evt = 1'b0;
    ovr_evt = 1'b1; bus_rd = 1'b1; bus_addr = 3'd5;
    @(negedge clk);
    ovr_evt = 1'b0; bus_rd = 1'b0;
    settle();
    chk("R11 event beats clear", {6'd0, brk_flag, ovr_flag}, 8'h01);
    bus_read(3'd5);
    par_err = 1'b1;
    bus_read(3'd5);
    settle();
    chk("R11 parity level kept", int_id, 8'h06);
    par_err = 1'b0;
    settle();

    // R7 one-edge latency
    chk("R7 before", int_id, 8'h01);
    frm_err = 1'b1;
    #1;
    chk("R7 same cycle", int_id, 8'h01);
    @(negedge clk);
    chk("R7 next edge", int_id, 8'h06);
    fifo_on = 1'b1;
    @(negedge clk);
    chk("R6 fifo bits", int_id, 8'hC6);
    frm_err = 1'b0; fifo_on = 1'b0;
    settle();

    summary();
  end

endmodule